// File: doc/BRIEF.md
# Expansion Slot Probe Sequencer

This block is a small bus master that runs once after reset and finds out which of the twelve expansion slots hold a card. The main board is entered first as slot 0 with a fixed identifier and no bus traffic. After that, each slot from 1 up to 12 is probed in turn. A probe is a zero byte written to the slot's command register, followed by two byte reads that assemble a 16-bit option identifier, most significant byte first. Every access is a request/acknowledge handshake. Any access that ends in a bus timeout drops the slot.

Each card that answers all three accesses gets an entry in a thirteen-deep result table, holding its slot number and identifier. The block also keeps a running count of entries. Software or a later boot stage reads the table through a combinational index port. When slot 12 has been handled, a done flag rises. A start pulse aborts any scan in progress, clears the table and begins again.

The state machine has six states. In SELF it writes the main-board entry. In WRITE it issues the command write. In READ_HI and READ_LO it issues the two identifier reads. In ADVANCE it steps the slot or leaves the scan. DONE is the idle state after the scan. Its transitions are:
- reset or start goes to SELF;
- SELF goes to WRITE;
- WRITE goes to READ_HI on acknowledge;
- READ_HI goes to READ_LO on acknowledge;
- READ_LO goes to ADVANCE on acknowledge, with an entry stored;
- any access state goes to ADVANCE on timeout;
- ADVANCE goes to WRITE for the next slot, or to DONE after slot 12.

Top module: `slot_probe_seq`

## Requirements
- R1: After reset or start, the count reads 0 and no bus request is made for one cycle. On the next clock, entry 0 is written with slot 0 and identifier MAIN_ID (default 0x0001), and the count becomes 1.
- R2: Slots are probed strictly in ascending order from 1 to 12. The base address of slot s is s × 0x200000.
- R3: A probe of slot s is a write (bus_we=1, bus_wdata=0x00) to base+5, then a read of base, then a read of base+1, in that order. bus_req, bus_addr and bus_we hold steady until bus_ack or bus_timeout is seen at a clock edge.
- R4: A slot that acknowledges all three accesses is stored at table index equal to the current count. The stored identifier is the byte from base in bits 15:8 and the byte from base+1 in bits 7:0. The count then rises by exactly one.
- R5: A timeout on any of the three accesses drops the slot. The slot gets no entry, its remaining accesses are skipped, and probing continues with the next slot.
- R6: When bus_ack and bus_timeout are both high in the same cycle, the timeout wins and the slot is dropped.
- R7: done rises after slot 12 is handled. It stays high with bus_req low until the next start.
- R8: start, in any state, aborts the scan: the table and count are cleared and the sequence restarts at R1.
- R9: Reading tbl_idx below the count returns the stored slot and identifier. Any index at or above the count, including 13 to 15, returns zero in both fields.
- R10: The count never exceeds 13. With every slot answering, the count reaches exactly 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Restart the scan with a cleared table |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W (32) | Byte address of the access |
| bus_wdata | output | 8 | Write data (always zero) |
| bus_rdata | input | 8 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Access completed |
| bus_timeout | input | 1 | Access timed out |
| done | output | 1 | Scan finished |
| entry_count | output | CNT_W (4) | Number of table entries |
| tbl_idx | input | IDX_W (4) | Table read index |
| tbl_slot | output | SLOT_W (4) | Slot number at tbl_idx |
| tbl_id | output | 16 | Option identifier at tbl_idx |

## Verification
The two functions that can fall in the same cycle are completion of an access and a bus timeout. They collide when the slave answers an access with bus_ack and bus_timeout high together. The bench provokes this on the command write of one slot, the high read of another and the low read of a third. In each case it expects the slot to be missing from the table. It also expects the access log to stop at the colliding access for that slot, with probing resuming at the next slot.

// File: rtl/probe_pkg.sv
package probe_pkg;

    typedef enum logic [2:0] {
        PS_SELF,
        PS_WRITE,
        PS_READ_HI,
        PS_READ_LO,
        PS_ADVANCE,
        PS_DONE
    } probe_state_t;

    localparam logic [2:0] OFS_CMD = 3'd5;
    localparam logic [2:0] OFS_HI  = 3'd0;
    localparam logic [2:0] OFS_LO  = 3'd1;

endpackage

// File: rtl/probe_addr_gen.sv
module probe_addr_gen #(
    parameter int          ADDR_W      = 32,
    parameter int          SLOT_W      = 4,
    parameter int unsigned SLOT_STRIDE = 32'h0020_0000
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic [2:0]        ofs,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] STRIDE_V = ADDR_W'(SLOT_STRIDE);

    always_comb begin
        addr = ADDR_W'(slot) * STRIDE_V + ADDR_W'(ofs);
    end
endmodule

// File: rtl/probe_table.sv
module probe_table #(
    parameter int DEPTH  = 13,
    parameter int SLOT_W = 4,
    parameter int ID_W   = 16,
    parameter int IDX_W  = 4,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [SLOT_W-1:0] rd_slot,
    output logic [ID_W-1:0]   rd_id,
    output logic [CNT_W-1:0]  count
);
    logic [SLOT_W-1:0] slot_mem [DEPTH];
    logic [ID_W-1:0]   id_mem   [DEPTH];
    logic [CNT_W-1:0]  count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (wr_en && (count_q < CNT_W'(DEPTH))) begin
            count_q <= count_q + 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_mem[g] <= '0;
                id_mem[g]   <= '0;
            end else if (clear) begin
                slot_mem[g] <= '0;
                id_mem[g]   <= '0;
            end else if (wr_en && (count_q == CNT_W'(g))) begin
                slot_mem[g] <= wr_slot;
                id_mem[g]   <= wr_id;
            end
        end
    end

    always_comb begin
        rd_slot = '0;
        rd_id   = '0;
        if (32'(rd_idx) < DEPTH) begin
            rd_slot = slot_mem[rd_idx];
            rd_id   = id_mem[rd_idx];
        end
    end

    assign count = count_q;
endmodule

// File: rtl/slot_probe_seq.sv
module slot_probe_seq #(
    parameter int              NUM_SLOTS   = 12,
    parameter int              ADDR_W      = 32,
    parameter int unsigned     SLOT_STRIDE = 32'h0020_0000,
    parameter logic [15:0]     MAIN_ID     = 16'h0001,
    localparam int             DEPTH       = NUM_SLOTS + 1,
    localparam int             SLOT_W      = $clog2(NUM_SLOTS + 1),
    localparam int             CNT_W       = $clog2(DEPTH + 1),
    localparam int             IDX_W       = $clog2(DEPTH),
    localparam int             ID_W        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic [7:0]        bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_timeout,
    output logic              done,
    output logic [CNT_W-1:0]  entry_count,
    input  logic [IDX_W-1:0]  tbl_idx,
    output logic [SLOT_W-1:0] tbl_slot,
    output logic [ID_W-1:0]   tbl_id
);
    import probe_pkg::*;

    probe_state_t      state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic [7:0]        hi_q, hi_d;
    logic              tbl_clear, tbl_wr;
    logic [SLOT_W-1:0] wr_slot;
    logic [ID_W-1:0]   wr_id;
    logic [2:0]        ofs;
    logic              resp_ok;

    // A timeout overrides a simultaneous acknowledge (R6)
    assign resp_ok = bus_ack && !bus_timeout;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_SELF;
            slot_q  <= '0;
            hi_q    <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            hi_q    <= hi_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        slot_d    = slot_q;
        hi_d      = hi_q;
        tbl_clear = 1'b0;
        tbl_wr    = 1'b0;
        wr_slot   = slot_q;
        wr_id     = {hi_q, bus_rdata};
        unique case (state_q)
            PS_SELF: begin
                tbl_wr  = 1'b1;
                wr_slot = '0;
                wr_id   = MAIN_ID;
                slot_d  = SLOT_W'(1);
                state_d = PS_WRITE;
            end
            PS_WRITE: begin
                if (bus_timeout)  state_d = PS_ADVANCE;
                else if (bus_ack) state_d = PS_READ_HI;
            end
            PS_READ_HI: begin
                if (bus_timeout) begin
                    state_d = PS_ADVANCE;
                end else if (bus_ack) begin
                    hi_d    = bus_rdata;
                    state_d = PS_READ_LO;
                end
            end
            PS_READ_LO: begin
                if (bus_timeout) begin
                    state_d = PS_ADVANCE;
                end else if (resp_ok) begin
                    tbl_wr  = 1'b1;
                    state_d = PS_ADVANCE;
                end
            end
            PS_ADVANCE: begin
                if (slot_q == SLOT_W'(NUM_SLOTS)) begin
                    state_d = PS_DONE;
                end else begin
                    slot_d  = slot_q + 1'b1;
                    state_d = PS_WRITE;
                end
            end
            PS_DONE: state_d = PS_DONE;
            default: state_d = PS_SELF;
        endcase
        if (start) begin
            state_d   = PS_SELF;
            slot_d    = '0;
            tbl_clear = 1'b1;
            tbl_wr    = 1'b0;
        end
    end

    always_comb begin
        bus_req = 1'b0;
        bus_we  = 1'b0;
        ofs     = OFS_CMD;
        done    = 1'b0;
        unique case (state_q)
            PS_WRITE:   begin bus_req = 1'b1; bus_we = 1'b1; ofs = OFS_CMD; end
            PS_READ_HI: begin bus_req = 1'b1; ofs = OFS_HI; end
            PS_READ_LO: begin bus_req = 1'b1; ofs = OFS_LO; end
            PS_DONE:    done = 1'b1;
            default:    ;
        endcase
    end

    assign bus_wdata = 8'h00;

    probe_addr_gen #(
        .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .SLOT_STRIDE(SLOT_STRIDE)
    ) u_addr (
        .slot(slot_q), .ofs(ofs), .addr(bus_addr)
    );

    probe_table #(
        .DEPTH(DEPTH), .SLOT_W(SLOT_W), .ID_W(ID_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n), .clear(tbl_clear), .wr_en(tbl_wr),
        .wr_slot(wr_slot), .wr_id(wr_id), .rd_idx(tbl_idx),
        .rd_slot(tbl_slot), .rd_id(tbl_id), .count(entry_count)
    );
endmodule

// File: rtl/probe_checker.sv
module probe_checker #(
    parameter int          ADDR_W      = 32,
    parameter int unsigned SLOT_STRIDE = 32'h0020_0000,
    parameter int          DEPTH       = 13,
    parameter int          CNT_W       = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_ack,
    input logic              bus_timeout,
    input logic              done,
    input logic [CNT_W-1:0]  entry_count
);
    assert_cmd_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |-> (bus_wdata == 8'h00 && (bus_addr % ADDR_W'(SLOT_STRIDE)) == ADDR_W'(5)));

    assert_hold_until_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && !bus_timeout && !start) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

    assert_timeout_no_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_timeout && !start) |=> (entry_count == $past(entry_count)));

    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (entry_count == $past(entry_count) || entry_count == $past(entry_count) + 1'b1));

    assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_req);

    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_restart_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (entry_count == '0 && !done && !bus_req));

    assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        entry_count <= CNT_W'(DEPTH));
endmodule

bind slot_probe_seq probe_checker #(
    .ADDR_W(ADDR_W), .SLOT_STRIDE(SLOT_STRIDE), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/tb_slot_probe_seq.sv
module tb_slot_probe_seq;
    localparam int STRIDE = 32'h0020_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        bus_req, bus_we, done;
    logic [31:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata = 8'h00;
    logic        bus_ack = 1'b0, bus_timeout = 1'b0;
    logic [3:0]  entry_count;
    logic [3:0]  tbl_idx = 4'd0;
    logic [3:0]  tbl_slot;
    logic [15:0] tbl_id;

    int checks = 0, fails = 0;
    bit          present [13];
    logic [15:0] ids [13];
    int          to_stage [13];
    int          both_stage [13];
    int          lat = 0;
    int          wcnt = 0;
    logic [31:0] log_addr [64];
    bit          log_we [64];
    int          log_n = 0;
    int          s_sl, s_of, s_st;

    always #10 clk = ~clk;

    slot_probe_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_timeout(bus_timeout),
        .done(done), .entry_count(entry_count),
        .tbl_idx(tbl_idx), .tbl_slot(tbl_slot), .tbl_id(tbl_id)
    );

    // Slave model: answers each request after lat idle cycles
    always @(negedge clk) begin
        if (!bus_req) begin
            bus_ack = 1'b0; bus_timeout = 1'b0; wcnt = 0;
        end else if (wcnt < lat) begin
            wcnt++; bus_ack = 1'b0; bus_timeout = 1'b0;
        end else begin
            wcnt = 0;
            s_sl = int'(bus_addr / STRIDE);
            s_of = int'(bus_addr % STRIDE);
            s_st = bus_we ? 1 : ((s_of == 0) ? 2 : 3);
            if (log_n < 64) begin
                log_addr[log_n] = bus_addr; log_we[log_n] = bus_we; log_n++;
            end
            bus_ack = 1'b0; bus_timeout = 1'b0;
            if (s_sl < 1 || s_sl > 12 || !present[s_sl]) bus_timeout = 1'b1;
            else if (to_stage[s_sl] == s_st) bus_timeout = 1'b1;
            else if (both_stage[s_sl] == s_st) begin bus_timeout = 1'b1; bus_ack = 1'b1; end
            else bus_ack = 1'b1;
            if (s_sl >= 1 && s_sl <= 12)
                bus_rdata = (s_st == 2) ? ids[s_sl][15:8] : ids[s_sl][7:0];
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic config_all(input bit pres, input int l);
        for (int i = 0; i < 13; i++) begin
            present[i] = pres; ids[i] = 16'hA000 + 16'(i * 16'h0111);
            to_stage[i] = 0; both_stage[i] = 0;
        end
        lat = l;
    endtask

    task automatic restart();
        @(negedge clk); #2 start = 1'b1; log_n = 0;
        @(negedge clk); #2 start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 3000) begin @(negedge clk); n++; end
        check(done, {tag, " watchdog R7"}, done, 1);
    endtask

    // Compare table, count and access log against a model built from R1-R5/R6 rules
    task automatic check_scan(input string tag);
        int          exp_n = 1, ln = 0, bad = 0;
        logic [3:0]  e_slot [13];
        logic [15:0] e_id [13];
        logic [31:0] e_addr [64];
        bit          e_we [64];
        e_slot[0] = 4'd0; e_id[0] = 16'h0001;
        for (int s = 1; s <= 12; s++) begin
            int  fail_at = 0;
            logic [31:0] b = 32'(s) * STRIDE;
            if (!present[s]) fail_at = 1;
            else if (to_stage[s] != 0) fail_at = to_stage[s];
            else if (both_stage[s] != 0) fail_at = both_stage[s];
            e_addr[ln] = b + 5; e_we[ln] = 1'b1; ln++;
            if (fail_at != 1) begin e_addr[ln] = b; e_we[ln] = 1'b0; ln++; end
            if (fail_at != 1 && fail_at != 2) begin e_addr[ln] = b + 1; e_we[ln] = 1'b0; ln++; end
            if (fail_at == 0) begin e_slot[exp_n] = 4'(s); e_id[exp_n] = ids[s]; exp_n++; end
        end
        check(entry_count == 4'(exp_n), {tag, " count R4"}, entry_count, exp_n);
        for (int i = 0; i < 16; i++) begin
            tbl_idx = 4'(i); #1;
            if (i < exp_n) begin
                check(tbl_slot == e_slot[i] && tbl_id == e_id[i], {tag, " entry R4"},
                      {tbl_slot, tbl_id}, {e_slot[i], e_id[i]});
            end else begin
                check(tbl_slot == 4'd0 && tbl_id == 16'd0, {tag, " unused entry zero R9"},
                      {tbl_slot, tbl_id}, 0);
            end
        end
        tbl_idx = 4'd0;
        check(log_n == ln, {tag, " access count R5"}, log_n, ln);
        for (int i = 0; i < ln && i < log_n; i++)
            if (log_addr[i] != e_addr[i] || log_we[i] != e_we[i]) begin
                if (bad == 0)
                    check(1'b0, {tag, " access order R2 R3"}, log_addr[i], e_addr[i]);
                bad++;
            end
        if (bad == 0) check(1'b1, {tag, " access order R2 R3"}, 0, 0);
    endtask

    task automatic t_reset_and_mixed();
        config_all(1'b0, 0);
        present[2] = 1'b1; present[5] = 1'b1; present[12] = 1'b1;
        repeat (3) @(negedge clk);
        check(entry_count == 0 && !bus_req && !done, "reset state R1", {entry_count, bus_req, done}, 0);
        #2 rst_n = 1'b1;
        @(negedge clk); #1;
        check(entry_count == 1 && bus_req && bus_we && bus_addr == 32'h0020_0005,
              "first access after slot 0 entry R1", bus_addr, 32'h0020_0005);
        tbl_idx = 4'd0; #1;
        check(tbl_slot == 0 && tbl_id == 16'h0001, "main board entry R1", tbl_id, 16'h0001);
        wait_done("mixed");
        check_scan("mixed");
    endtask

    task automatic t_all_empty();
        config_all(1'b0, 0);
        restart();
        wait_done("empty");
        check_scan("empty");
    endtask

    task automatic t_all_full_latency();
        config_all(1'b1, 2);
        restart();
        wait_done("full");
        check(entry_count == 4'd13, "full count R10", entry_count, 13);
        check_scan("full");
    endtask

    task automatic t_stage_timeouts();
        config_all(1'b1, 1);
        to_stage[1] = 1; to_stage[3] = 2; to_stage[4] = 3; to_stage[11] = 3;
        restart();
        wait_done("timeouts");
        check_scan("timeouts R5");
    endtask

    task automatic t_ack_and_timeout();
        config_all(1'b1, 0);
        both_stage[8] = 1; both_stage[6] = 2; both_stage[7] = 3;
        restart();
        wait_done("collide");
        check_scan("collide R6");
    endtask

    task automatic t_restart_mid_scan();
        config_all(1'b1, 0);
        restart();
        repeat (15) @(negedge clk);
        config_all(1'b0, 0);
        present[9] = 1'b1; ids[9] = 16'h5AC3;
        restart();
        tbl_idx = 4'd1; #1;
        check(entry_count == 0 && tbl_id == 16'd0 && !done, "restart clears table R8",
              {entry_count, tbl_id}, 0);
        tbl_idx = 4'd0;
        wait_done("restart");
        check_scan("restart R8");
    endtask

    task automatic t_done_hold();
        repeat (10) @(negedge clk);
        #1;
        check(done && !bus_req, "done holds without requests R7", {done, bus_req}, 2'b10);
    endtask

    initial begin
        t_reset_and_mixed();
        t_done_hold();
        t_all_empty();
        t_all_full_latency();
        t_stage_timeouts();
        t_ack_and_timeout();
        t_restart_mid_scan();
        t_done_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule